// File: doc/BRIEF.md
# TV Sound Decoder Control Slave (I2C)

This block is the two-wire control port of a television sound decoder. A host writes one control byte that sets up the audio path: input mode, reference clock output, external source, mute, forced mono and language choice. The host can also read back one status byte. That byte carries the stereo and bilingual detector flags and a marker that shows the control register has not been written since reset.

The block listens on one of three fixed 7-bit addresses, chosen by a three-level board strap that arrives already encoded as two bits. SCL and SDA are brought into the system clock domain before they are used. The block drives SDA only as an open-drain pull-down, through an output enable. A written byte is held back and applied to the control outputs only when the STOP condition closes the transfer. A byte that is cut short is dropped.

Top module: `snd_ctl_i2c_slave`

## Requirements
- R1: On synchronous active-low reset the control word becomes 01h. That means language select 01 and every other field 0. The never-written marker is set and sda_oe is low.
- R2: `addr_sel` picks the 7-bit slave address: 00 gives 50h, 01 gives 40h, 10 gives 42h, and 11 is treated as 01 (40h). When the address matches, the slave acknowledges by raising sda_oe for the ninth SCL clock. It changes sda_oe only after a detected SCL falling edge.
- R3: When the address does not match, there is no acknowledge, and the bus is ignored until the next START. A repeated START always restarts address reception. While idle or ignoring, sda_oe stays low.
- R4: Bits are taken MSB first on SCL rising edges. The control byte fields are: bit7 test_en, bit6 baseband_sel, bit5 refclk_en, bit4 ext_sel, bit3 mute, bit2 force_mono, bits1:0 lang_sel (00 both, 01 main, 10 sub).
- R5: A complete written byte reaches the control outputs only on the STOP that ends the transfer, three system clocks after SDA rises. Until then the outputs keep their old value.
- R6: If STOP comes before all 8 bits of the data byte, the partial byte is discarded and the control word is unchanged.
- R7: Only the first data byte of a write is accepted. Later bytes get no acknowledge and are not applied.
- R8: A read returns the status byte MSB first: {stereo_det, bilingual_det, never-written marker, 00000}. It is sampled at the end of the address acknowledge. sda_oe is high only for 0 bits.
- R9: The never-written marker is cleared by the first committed write and does not come back before the next reset.
- R10: SCL and SDA pass through a two-stage synchronizer. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level as seen on the wire |
| addr_sel | input | 2 | Encoded address strap: 00 low, 01 open, 10 high |
| stereo_det | input | 1 | Stereo pilot detected |
| bilingual_det | input | 1 | Bilingual programme detected |
| test_en | output | 1 | Test mode enable |
| baseband_sel | output | 1 | 1 = baseband input, 0 = sound IF input |
| refclk_en | output | 1 | Reference clock output enable |
| ext_sel | output | 1 | External source selected |
| mute | output | 1 | Output mute |
| force_mono | output | 1 | Forced mono |
| lang_sel | output | 2 | Language select |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A behavioural model tracks the expected control word and marker, and the outputs are compared with it on every clock. Exact three-clock commit timing therefore separates "apply at STOP" from "apply at the acknowledge". The main write path is driven at each of the four strap codes with matching and mismatching addresses. This separates a correct address decode from one that acknowledges everything or swaps levels. Truncated bytes, a second data byte and a repeated START after a refused address each isolate one way a byte could leak into the register. Reads with different detector flag pairs, before and after the first write, separate the field order of the status byte and the clearing of the marker.

// File: rtl/snd_ctl_pkg.sv
// Shared types for the sound-decoder control slave.
// Assumes an 8-bit control word laid out as the register fields below.
package snd_ctl_pkg;

    localparam int DATA_W = 8;

    // Control word, MSB first as it arrives on the bus
    typedef struct packed {
        logic       test_en;
        logic       baseband;
        logic       refclk_en;
        logic       ext_src;
        logic       mute;
        logic       mono;
        logic [1:0] lang;
    } ctl_word_t;

    // Bus-level protocol phases of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } link_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL/SDA into the clock domain and flags bus events.
// Assumes the system clock is many times faster than SCL, so that each
// SCL phase lasts several clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronizer chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels
    always_comb begin
        scl_s     = scl_chain[STAGES-1];
        sda_s     = sda_chain[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_link_fsm.sv
// Byte-level slave protocol: address match, acknowledge, one write byte
// held pending until STOP, one status byte shifted out on read.
// Assumes synchronized inputs and single-cycle event strobes.
module i2c_link_fsm
    import snd_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR_LOW  = 7'h50,
    parameter logic [6:0] ADDR_OPEN = 7'h40,
    parameter logic [6:0] ADDR_HIGH = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] status_byte,
    output logic              sda_oe,
    output logic              commit_stb,
    output logic [DATA_W-1:0] commit_byte,
    output logic              bus_quiet
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    link_state_t       state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] tx;
    logic [DATA_W-1:0] pend;
    logic              pend_v;
    logic              rw;
    logic [6:0]        own_addr;

    // Strap decode to the active slave address
    always_comb begin
        unique case (addr_sel)
            2'b00:   own_addr = ADDR_LOW;
            2'b10:   own_addr = ADDR_HIGH;
            default: own_addr = ADDR_OPEN;
        endcase
    end

    // Protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            rw     <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            pend_v <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            pend_v <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST) begin
                        cnt <= '0;
                        if (sh[DATA_W-1:1] == own_addr) begin
                            state  <= ST_AACK;
                            rw     <= sh[0];
                            sda_oe <= 1'b1;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            state  <= ST_RDAT;
                            tx     <= status_byte;
                            sda_oe <= ~status_byte[DATA_W-1];
                        end else begin
                            state  <= ST_WDAT;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WDAT: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST) begin
                        state  <= ST_WACK;
                        pend   <= sh;
                        pend_v <= 1'b1;
                        sda_oe <= 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        state  <= ST_SKIP;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST - 1'b1) begin
                            state  <= ST_RACK;
                            sda_oe <= 1'b0;
                        end else begin
                            tx     <= {tx[DATA_W-2:0], 1'b0};
                            sda_oe <= ~tx[DATA_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) state <= ST_SKIP;
                end
                default: ;
            endcase
        end
    end

    // Commit request and idle indication toward the register and checker
    always_comb begin
        commit_stb  = stop_det & pend_v;
        commit_byte = pend;
        bus_quiet   = (state == ST_IDLE) || (state == ST_SKIP);
    end

endmodule

// File: rtl/snd_ctl_regs.sv
// Control register applied at STOP, never-written marker, status assembly.
// Assumes commit_stb is a single-cycle strobe.
module snd_ctl_regs
    import snd_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_stb,
    input  logic [DATA_W-1:0] commit_byte,
    input  logic              stereo_det,
    input  logic              bilingual_det,
    output logic [DATA_W-1:0] ctl_q,
    output logic              fresh_q,
    output logic [DATA_W-1:0] status_byte
);

    // Register update and marker clear on a committed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= RESET_VAL;
            fresh_q <= 1'b1;
        end else if (commit_stb) begin
            ctl_q   <= commit_byte;
            fresh_q <= 1'b0;
        end
    end

    // Status byte for reads
    always_comb begin
        status_byte = {stereo_det, bilingual_det, fresh_q, {(DATA_W-3){1'b0}}};
    end

endmodule

// File: rtl/snd_ctl_i2c_slave.sv
// Top: I2C control/status slave of the sound decoder.
// Assumes an external open-drain pad: SDA is pulled low while sda_oe is high.
module snd_ctl_i2c_slave
    import snd_ctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LOW    = 7'h50,
    parameter logic [6:0] ADDR_OPEN   = 7'h40,
    parameter logic [6:0] ADDR_HIGH   = 7'h42,
    parameter logic [7:0] RESET_VAL   = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] addr_sel,
    input  logic       stereo_det,
    input  logic       bilingual_det,
    output logic       test_en,
    output logic       baseband_sel,
    output logic       refclk_en,
    output logic       ext_sel,
    output logic       mute,
    output logic       force_mono,
    output logic [1:0] lang_sel,
    output logic       sda_oe
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              commit_stb;
    logic [DATA_W-1:0] commit_byte;
    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] ctl_q;
    logic              fresh_q;
    logic              bus_quiet;
    ctl_word_t         ctl_w;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_link_fsm #(
        .ADDR_LOW  (ADDR_LOW),
        .ADDR_OPEN (ADDR_OPEN),
        .ADDR_HIGH (ADDR_HIGH)
    ) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_sel    (addr_sel),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .commit_stb  (commit_stb),
        .commit_byte (commit_byte),
        .bus_quiet   (bus_quiet)
    );

    snd_ctl_regs #(.RESET_VAL(RESET_VAL)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_stb    (commit_stb),
        .commit_byte   (commit_byte),
        .stereo_det    (stereo_det),
        .bilingual_det (bilingual_det),
        .ctl_q         (ctl_q),
        .fresh_q       (fresh_q),
        .status_byte   (status_byte)
    );

    // Field breakout of the control word
    always_comb begin
        ctl_w        = ctl_word_t'(ctl_q);
        test_en      = ctl_w.test_en;
        baseband_sel = ctl_w.baseband;
        refclk_en    = ctl_w.refclk_en;
        ext_sel      = ctl_w.ext_src;
        mute         = ctl_w.mute;
        force_mono   = ctl_w.mono;
        lang_sel     = ctl_w.lang;
    end

endmodule

// File: rtl/snd_ctl_i2c_checker.sv
// Protocol and register properties of the control slave, bound to the top.
// Assumes the top's internal names ctl_q, fresh_q, stop_det, start_det,
// scl_fall and bus_quiet.
module snd_ctl_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_q,
    input logic       fresh_q,
    input logic       stop_det,
    input logic       start_det,
    input logic       scl_fall,
    input logic       sda_oe,
    input logic       bus_quiet
);

    assert_fresh_is_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_q |-> (ctl_q == 8'h01));

    assert_oe_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_quiet_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_quiet |-> !sda_oe);

    assert_ctl_moves_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(stop_det));

    assert_fresh_clears_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fresh_q) |-> $past(stop_det));

    assert_fresh_never_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(fresh_q));

    assert_start_stop_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

bind snd_ctl_i2c_slave snd_ctl_i2c_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_q     (ctl_q),
    .fresh_q   (fresh_q),
    .stop_det  (stop_det),
    .start_det (start_det),
    .scl_fall  (scl_fall),
    .sda_oe    (sda_oe),
    .bus_quiet (bus_quiet)
);

// File: tb/sim_snd_ctl_i2c_slave.sv
// Bench: bus-master tasks plus a behavioural model of the control word,
// compared on every clock.
module sim_snd_ctl_i2c_slave;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic       stereo_det = 1'b0;
    logic       bilingual_det = 1'b0;
    logic       test_en, baseband_sel, refclk_en, ext_sel, mute, force_mono;
    logic [1:0] lang_sel;
    logic       sda_oe;
    logic       sda_bus;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   cmp_on = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_ctl = 8'h01;
    bit   exp_fresh = 1'b1;
    bit   upd_pending = 1'b0;
    int   upd_at = 0;
    logic [7:0] upd_val = 8'h00;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_ctl_i2c_slave u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .addr_sel      (addr_sel),
        .stereo_det    (stereo_det),
        .bilingual_det (bilingual_det),
        .test_en       (test_en),
        .baseband_sel  (baseband_sel),
        .refclk_en     (refclk_en),
        .ext_sel       (ext_sel),
        .mute          (mute),
        .force_mono    (force_mono),
        .lang_sel      (lang_sel),
        .sda_oe        (sda_oe)
    );

    function automatic logic [7:0] ctl_out();
        return {test_en, baseband_sel, refclk_en, ext_sel, mute, force_mono, lang_sel};
    endfunction

    // Model: apply a scheduled commit three clocks after STOP
    always @(posedge clk) begin
        if (upd_pending && cyc == upd_at) begin
            exp_ctl     <= upd_val;
            exp_fresh   <= 1'b0;
            upd_pending <= 1'b0;
        end
        cyc <= cyc + 1;
    end

    // Per-clock comparison of the control outputs against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (ctl_out() !== exp_ctl) begin
                fails++;
                $display("FAIL R5 cycle %0d: ctl=%02h expected %02h", cyc, ctl_out(), exp_ctl);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b0; tick(8);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic send_bit(input logic b);
        tick(4); sda_m = b; tick(4);
        scl_m = 1'b1; tick(8);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        tick(4); sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        ack = sda_bus; tick(4);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            tick(4); sda_m = 1'b1; tick(4);
            scl_m = 1'b1; tick(4);
            v[i] = sda_bus; tick(4);
            scl_m = 1'b0;
        end
        send_bit(1'b1);
    endtask

    task automatic bus_stop(input bit commit, input logic [7:0] val);
        tick(4); sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b1;
        if (commit) begin
            upd_at      = cyc + 2;
            upd_val     = val;
            upd_pending = 1'b1;
        end
        tick(8);
    endtask

    task automatic write_one(input logic [7:0] abyte, input logic [7:0] d,
                             input logic exp_ack, input string req);
        logic a;
        bus_start();
        send_byte(abyte, a);
        check(req, {7'd0, a}, {7'd0, ~exp_ack});
        if (exp_ack) begin
            send_byte(d, a);
            check("R4", {7'd0, a}, 8'd0);
        end
        bus_stop(exp_ack, d);
    endtask

    task automatic read_status(input logic [7:0] abyte, input logic [7:0] expv);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(abyte, a);
        check("R2", {7'd0, a}, 8'd0);
        recv_byte(v);
        check("R8", v, expv);
        bus_stop(1'b0, 8'h00);
    endtask

    initial begin
        logic a;
        tick(5);
        // R1: reset state
        check("R1", ctl_out(), 8'h01);
        check("R1", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1'b1;
        tick(10);

        // R8 R1: status before any write shows the marker
        stereo_det = 1'b1; bilingual_det = 1'b0;
        read_status(8'h81, 8'hA0);

        // R4 R5: write, outputs hold until STOP, then fields decode
        bus_start();
        send_byte(8'h80, a); check("R2", {7'd0, a}, 8'd0);
        send_byte(8'hB6, a); check("R4", {7'd0, a}, 8'd0);
        tick(20);
        check("R5", ctl_out(), 8'h01);
        bus_stop(1'b1, 8'hB6);
        check("R4", {7'd0, test_en, baseband_sel, refclk_en, ext_sel, mute, force_mono},
              8'b0010_1101);
        check("R4", {6'd0, lang_sel}, 8'h02);

        // R9: marker cleared
        stereo_det = 1'b0; bilingual_det = 1'b1;
        read_status(8'h81, 8'h40);

        // R3: strap high, wrong address refused, data ignored
        addr_sel = 2'b10;
        bus_start();
        send_byte(8'h80, a); check("R3", {7'd0, a}, 8'd1);
        send_byte(8'h11, a); check("R3", {7'd0, a}, 8'd1);
        bus_stop(1'b0, 8'h00);
        check("R3", ctl_out(), 8'hB6);

        // R2: each strap level
        write_one(8'h84, 8'h5A, 1'b1, "R2");
        addr_sel = 2'b00;
        write_one(8'h80, 8'h77, 1'b0, "R2");
        write_one(8'hA0, 8'h03, 1'b1, "R2");
        addr_sel = 2'b11;
        write_one(8'h80, 8'h0C, 1'b1, "R2");

        // R6: truncated data byte dropped
        bus_start();
        send_byte(8'h80, a); check("R6", {7'd0, a}, 8'd0);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop(1'b0, 8'h00);
        check("R6", ctl_out(), 8'h0C);

        // R3: repeated START after a refused address
        bus_start();
        send_byte(8'h84, a); check("R3", {7'd0, a}, 8'd1);
        bus_start();
        send_byte(8'h80, a); check("R3", {7'd0, a}, 8'd0);
        send_byte(8'h27, a); check("R3", {7'd0, a}, 8'd0);
        bus_stop(1'b1, 8'h27);

        // R7: second data byte not acknowledged, first one applied
        bus_start();
        send_byte(8'h80, a);
        send_byte(8'h91, a); check("R7", {7'd0, a}, 8'd0);
        send_byte(8'h6E, a); check("R7", {7'd0, a}, 8'd1);
        bus_stop(1'b1, 8'h91);
        check("R7", ctl_out(), 8'h91);

        // R8 R10: both flags, marker stays clear
        stereo_det = 1'b1; bilingual_det = 1'b1;
        read_status(8'h81, 8'hC0);
        check("R9", {7'd0, exp_fresh}, 8'd0);

        tick(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule